// File: doc/BRIEF.md
# SCSI DMA Channel Control Register Bank

This block is the host-visible register file of a DMA channel that serves a SCSI controller core. It holds four 32-bit words. A host bus writes them one word at a time and reads them back through a combinational port. Word 0 is the channel control/status word. Word 1 is the buffer address. Words 2 and 3 are plain storage. The data mover and address translation are separate blocks that use these outputs.

A write to the control word does not store the value as it arrives. The value is rewritten first. A reset request bit sends a one-cycle reset pulse to the attached SCSI core. Without that bit, a request bit at position 6 clears itself. An all-zero write stores 0x40 in place of the zero. The version nibble is always forced to 0xA. A control write with the interrupt-enable bit (bit 4) clear also sends a one-cycle strobe that drops the channel interrupt. A write to the address word replaces the whole control word with an "address loaded" flag. A transfer-complete pulse from the SCSI core sets the done bit, which is bit 0 of the control word.

Top module: `scsi_dma_regs`

## Requirements
- R1: After reset, word 0 reads 0xA0000000, words 1 to 3 read 0, and both core_rst_o and irq_clr_o are low.
- R2: addr_i[3:2] selects the word for both reads and writes: 0 is control, 1 is address, 2 and 3 are plain storage. addr_i[1:0] has no effect.
- R3: A control write with wdata_i[7]=1 drives core_rst_o high for exactly one cycle, the cycle after the write edge. The stored value keeps bit 7 and is otherwise rewritten as in R6.
- R4: A control write with wdata_i[7]=0 and wdata_i[6]=1 stores the value with bit 6 cleared.
- R5: A control write of exactly 0x00000000 stores 0xA0000040.
- R6: Every control write stores bits [27:0] of the rewritten value, with bits [31:28] forced to 0xA. An all-zero upper nibble in the written value does not count as a zero write.
- R7: A control write with wdata_i[4]=0 drives irq_clr_o high for exactly the cycle after the write edge. With wdata_i[4]=1 the strobe stays low.
- R8: A write to word 1 stores wdata_i in word 1 and replaces word 0 with 0x04000000.
- R9: When xfer_done_i is high at a clock edge, bit 0 of word 0 reads 1 after that edge. This holds even when a write to word 0 or word 1 happens on the same edge. The bit stays set until the next write to word 0 or word 1.
- R10: Words 2 and 3 store wdata_i unchanged. A word keeps its value while no write selects it, apart from the word-0 updates in R8 and R9.
- R11: Reads are combinational from addr_i and change no state. Reading the same word twice returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Word write strobe |
| addr_i | input | 4 | Byte address; bits [3:2] pick the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word at addr_i |
| xfer_done_i | input | 1 | Transfer-complete pulse from the SCSI core |
| core_rst_o | output | 1 | One-cycle reset pulse to the SCSI core |
| irq_clr_o | output | 1 | One-cycle interrupt deassert strobe |

## Verification
The assertions assume that every input is a known value once reset is released. They also assume that xfer_done_i and wr_en_i are sampled as single-cycle qualifiers, so a write lasts exactly one edge. The stimulus follows this. Each write raises wr_en_i for one cycle, and xfer_done_i is high only during that cycle or during a separate one-cycle pulse. The random data is weighted toward zero words and words with bit 6 or bit 7 set, so the rewrite branches are reached often. The low address bits are randomised on every access.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_REGS  = 4;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned WORD_LSB  = 2;
  localparam int unsigned IDX_W     = $clog2(NUM_REGS);

  localparam int unsigned CTRL_IDX  = 0;
  localparam int unsigned BUFA_IDX  = 1;

  localparam int unsigned BIT_DONE  = 0;
  localparam int unsigned BIT_IEN   = 4;
  localparam int unsigned BIT_SCLR  = 6;
  localparam int unsigned BIT_RST   = 7;
  localparam int unsigned VER_W     = 4;

  localparam logic [VER_W-1:0]  VERSION    = 4'hA;
  localparam logic [DATA_W-1:0] ZERO_SUBST = 32'h0000_0040;
  localparam logic [DATA_W-1:0] LOADED_VAL = 32'h0400_0000;
  localparam logic [DATA_W-1:0] CTRL_RST   = {VERSION, {(DATA_W-VER_W){1'b0}}};

  typedef struct packed {
    logic core_rst;
    logic irq_clr;
  } side_req_t;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import scsi_dma_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_REGS,
  parameter int unsigned A_W    = ADDR_W,
  parameter int unsigned LSB    = WORD_LSB,
  localparam int unsigned I_W   = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [A_W-1:0]    addr_i,
  output logic [N_REGS-1:0] wr_sel_o,
  output logic [I_W-1:0]    rd_idx_o
);
  logic [I_W-1:0] idx;
  assign idx      = addr_i[LSB +: I_W];
  assign rd_idx_o = idx;

  for (genvar g = 0; g < N_REGS; g++) begin : g_sel
    assign wr_sel_o[g] = wr_en_i && (idx == I_W'(g));
  end

  // R2
  onehot_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
  // R2
  sel_follows_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> $countones(wr_sel_o) == 1);
endmodule

// File: rtl/dma_ctrl_rewrite.sv
module dma_ctrl_rewrite
  import scsi_dma_pkg::*;
#(
  parameter int unsigned D_W = DATA_W
) (
  input  logic [D_W-1:0] wdata_i,
  output logic [D_W-1:0] ctrl_o,
  output side_req_t      req_o
);
  logic [D_W-1:0] pre;

  always_comb begin
    pre = wdata_i;
    if (wdata_i[BIT_RST]) begin
      pre = wdata_i;
    end else if (wdata_i[BIT_SCLR]) begin
      pre[BIT_SCLR] = 1'b0;
    end else if (wdata_i == '0) begin
      pre = ZERO_SUBST;
    end
  end

  assign ctrl_o           = {VERSION, pre[D_W-VER_W-1:0]};
  assign req_o.core_rst   = wdata_i[BIT_RST];
  assign req_o.irq_clr    = !wdata_i[BIT_IEN];
endmodule

// File: rtl/dma_pulse_reg.sv
module dma_pulse_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] pulse_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= req_i[g];
    end
    assign pulse_o[g] = q;

    // R3 R7
    pulse_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[g] |=> pulse_o[g]);
    // R3 R7
    pulse_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i[g] |=> !pulse_o[g]);
  end
endmodule

// File: rtl/dma_reg_bank.sv
module dma_reg_bank
  import scsi_dma_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_REGS,
  parameter int unsigned D_W    = DATA_W,
  localparam int unsigned I_W   = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REGS-1:0] wr_sel_i,
  input  logic [D_W-1:0]    wdata_i,
  input  logic [D_W-1:0]    ctrl_new_i,
  input  logic              done_i,
  input  logic [I_W-1:0]    rd_idx_i,
  output logic [D_W-1:0]    rdata_o
);
  logic [D_W-1:0] regs_q [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    if (g == CTRL_IDX) begin : g_ctrl
      logic [D_W-1:0] ctrl_d;
      always_comb begin
        if (wr_sel_i[CTRL_IDX])      ctrl_d = ctrl_new_i;
        else if (wr_sel_i[BUFA_IDX]) ctrl_d = LOADED_VAL;
        else                         ctrl_d = regs_q[g];
        ctrl_d[BIT_DONE] = ctrl_d[BIT_DONE] | done_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[g] <= CTRL_RST;
        else         regs_q[g] <= ctrl_d;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          regs_q[g] <= '0;
        else if (wr_sel_i[g]) regs_q[g] <= wdata_i;
      end
      // R10
      hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_sel_i[g] |=> $stable(regs_q[g]));
      // R8 R10
      store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_sel_i[g] |=> regs_q[g] == $past(wdata_i));
    end
  end

  assign rdata_o = regs_q[rd_idx_i];

  // R6
  version_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel_i[CTRL_IDX] |=> regs_q[CTRL_IDX][D_W-1 -: VER_W] == VERSION);
  // R4
  selfclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel_i[CTRL_IDX] && wdata_i[BIT_SCLR] && !wdata_i[BIT_RST]
    |=> !regs_q[CTRL_IDX][BIT_SCLR]);
  // R8
  loaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel_i[BUFA_IDX] |=> regs_q[CTRL_IDX][D_W-1:1] == LOADED_VAL[D_W-1:1]);
  // R9
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> regs_q[CTRL_IDX][BIT_DONE]);
  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[CTRL_IDX][BIT_DONE] && !wr_sel_i[CTRL_IDX] && !wr_sel_i[BUFA_IDX]
    |=> regs_q[CTRL_IDX][BIT_DONE]);
endmodule

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
  import scsi_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              xfer_done_i,
  output logic              core_rst_o,
  output logic              irq_clr_o
);
  logic [NUM_REGS-1:0] wr_sel;
  logic [IDX_W-1:0]    rd_idx;
  logic [DATA_W-1:0]   ctrl_new;
  side_req_t           req_raw;
  logic [1:0]          req_gated;
  logic [1:0]          pulses;

  dma_reg_decode #(.N_REGS(NUM_REGS), .A_W(ADDR_W), .LSB(WORD_LSB)) i_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_sel_o (wr_sel),
    .rd_idx_o (rd_idx)
  );

  dma_ctrl_rewrite #(.D_W(DATA_W)) i_rewrite (
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl_new),
    .req_o   (req_raw)
  );

  assign req_gated = {req_raw.core_rst & wr_sel[CTRL_IDX],
                      req_raw.irq_clr  & wr_sel[CTRL_IDX]};

  dma_pulse_reg #(.W(2)) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_gated),
    .pulse_o (pulses)
  );
  assign core_rst_o = pulses[1];
  assign irq_clr_o  = pulses[0];

  dma_reg_bank #(.N_REGS(NUM_REGS), .D_W(DATA_W)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_sel_i   (wr_sel),
    .wdata_i    (wdata_i),
    .ctrl_new_i (ctrl_new),
    .done_i     (xfer_done_i),
    .rd_idx_i   (rd_idx),
    .rdata_o    (rdata_o)
  );

  // R3
  core_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i[WORD_LSB +: IDX_W] == IDX_W'(CTRL_IDX) && wdata_i[BIT_RST]
    |=> core_rst_o);
  // R3
  core_rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !core_rst_o);
  // R7
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i[WORD_LSB +: IDX_W] == IDX_W'(CTRL_IDX) && !wdata_i[BIT_IEN]
    |=> irq_clr_o);
  // R7
  irq_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wdata_i[BIT_IEN] |=> !irq_clr_o);
endmodule

// File: tb/test_scsi_dma_regs.sv
module test_scsi_dma_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        xfer_done_i = 1'b0;
  logic        core_rst_o;
  logic        irq_clr_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          finished = 0;
  logic [31:0] mdl [4];

  always #5 clk_i = ~clk_i;

  scsi_dma_regs i_scsi_dma_regs (.*);

  function automatic logic [31:0] ctrl_model(input logic [31:0] v);
    logic [31:0] r;
    if (v[7])      r = v;
    else if (v[6]) r = v & ~32'h40;
    else if (v == 0) r = 32'h40;
    else           r = v;
    return (r & 32'h0FFF_FFFF) | 32'hA000_0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input int idx, input string req);
    addr_i = {idx[1:0], 2'($urandom_range(0, 3))};
    #1;
    chk(req, rdata_o, mdl[idx]);
  endtask

  task automatic rd_all(input string req);
    for (int i = 0; i < 4; i++) rd_chk(i, req);
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input bit done);
    bit exp_rst, exp_irq;
    @(negedge clk_i);
    wr_en_i = 1'b1;
    addr_i = {idx[1:0], 2'($urandom_range(0, 3))};
    wdata_i = d;
    xfer_done_i = done;
    exp_rst = (idx == 0) && d[7];
    exp_irq = (idx == 0) && !d[4];
    @(negedge clk_i);
    wr_en_i = 1'b0;
    xfer_done_i = 1'b0;
    #1;
    chk("R3 core_rst pulse", 32'(core_rst_o), 32'(exp_rst));
    chk("R7 irq_clr strobe", 32'(irq_clr_o), 32'(exp_irq));
    if (idx == 0) mdl[0] = ctrl_model(d);
    else if (idx == 1) begin mdl[1] = d; mdl[0] = 32'h0400_0000; end
    else mdl[idx] = d;
    if (done) mdl[0][0] = 1'b1;
    rd_all("R2 R10 readback");
    @(negedge clk_i);
    #1;
    chk("R3 core_rst single cycle", 32'(core_rst_o), 32'd0);
    chk("R7 irq_clr single cycle", 32'(irq_clr_o), 32'd0);
  endtask

  task automatic done_pulse();
    @(negedge clk_i);
    xfer_done_i = 1'b1;
    @(negedge clk_i);
    xfer_done_i = 1'b0;
    mdl[0][0] = 1'b1;
    rd_chk(0, "R9 done sets bit0");
  endtask

  initial begin
    void'($urandom(32'h1357_2468));
    mdl[0] = 32'hA000_0000; mdl[1] = 0; mdl[2] = 0; mdl[3] = 0;
    #1;
    chk("R1 core_rst low in reset", 32'(core_rst_o), 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_all("R1 reset value");
    chk("R1 irq_clr idle", 32'(irq_clr_o), 32'd0);

    wr(0, 32'h0000_0000, 0);
    rd_chk(0, "R5 zero write gives 0xA0000040");
    wr(0, 32'h0000_0050, 0);
    rd_chk(0, "R4 bit6 self-clears");
    wr(0, 32'h0000_00C0, 0);
    rd_chk(0, "R3 bit7 keeps bit6");
    wr(0, 32'hF000_0000, 0);
    rd_chk(0, "R6 upper nibble only is not zero");
    wr(0, 32'h5123_4510, 0);
    rd_chk(0, "R6 version forced");
    wr(1, 32'hDEAD_BEEF, 0);
    rd_chk(0, "R8 loaded flag");
    rd_chk(1, "R8 address stored");
    done_pulse();
    rd_chk(0, "R11 repeat read stable");
    rd_chk(0, "R11 repeat read stable");
    wr(2, 32'h1234_5678, 0);
    wr(3, 32'h8765_4321, 0);
    rd_chk(0, "R9 done bit persists");
    wr(0, 32'h0000_0010, 1);
    rd_chk(0, "R9 done with ctrl write");
    wr(1, 32'h0000_1000, 1);
    rd_chk(0, "R9 done with addr write");

    for (int n = 0; n < 400; n++) begin
      int idx;
      logic [31:0] d;
      idx = $urandom_range(0, 3);
      d = $urandom;
      case ($urandom_range(0, 5))
        0: d = 32'h0;
        1: d[7] = 1'b1;
        2: begin d[7] = 1'b0; d[6] = 1'b1; end
        default: ;
      endcase
      if ($urandom_range(0, 7) == 0) done_pulse();
      wr(idx, d, $urandom_range(0, 3) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule